// File: doc/BRIEF.md
# Per-Channel Zero Suppression Filter

The filter sits behind the digitiser of one 128-channel front-end chip. For every event it receives the samples channel by channel, each channel carrying a programmed number of time samples and closed by an end-of-channel marker. For each channel it subtracts a per-channel pedestal from every sample, sums the result, and keeps the channel only when the mean charge reaches the channel's noise sigma scaled by a programmable fractional factor. A bypass setting keeps every well-formed channel regardless of charge.

Kept channels are stored in a frame buffer while the event is still arriving. Once the last channel has been judged, the filter sends one frame of 16-bit words: a four-word header carrying the chip number, the count of kept channels, the samples per channel and an error code, followed by one record per kept channel. While the frame is being sent the filter reports itself busy and accepts no samples. Pedestal and sigma tables are loaded through a small write port between events.

Top module: `zs_filter`

## Requirements
- R1: After reset `out_valid_o`, `out_first_o`, `out_last_o` and `busy_o` are low.
- R2: For a well-formed channel with S = sum over its samples of (sample - pedestal), the channel is kept when S*256 >= ns * sigma * factor and dropped otherwise; equality keeps it.
- R3: `factor_i` is an unsigned 12-bit value with 8 fractional bits (0x100 is 1.0, 0x0CC is about 0.8).
- R4: With `bypass_i` high every well-formed channel is kept, whatever its charge.
- R5: A frame starts with four header words: {4'h0, chip_id, kept count}, {ns, error byte}, 16'h0000, 16'h0000.
- R6: Each kept channel follows as a record word {8'h00, channel number 0..127} and then ns words holding the raw 13-bit samples zero-extended to 16 bits; records appear in ascending channel order, and numbers above 127 never appear.
- R7: The header's count equals the number of records, and the first header word is valid in the second cycle after the clock edge that accepts the end-of-channel marker of channel 127.
- R8: A channel whose end marker arrives after fewer or more than ns samples is dropped and sets error bit 0.
- R9: A channel that would be kept but whose record does not fit in the remaining frame buffer (2048 words) is dropped and sets error bit 1; the error byte is zero when neither error occurred.
- R10: A table write is taken only when the filter is idle between events and no sample is presented in the same cycle; otherwise it is ignored. Samples presented while `busy_o` is high are ignored.
- R11: `out_first_o` marks exactly the first word of a frame and `out_last_o` exactly its last word; `busy_o` is low again in the cycle the last word is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_sel_i | input | 1 | Table select: 0 pedestal, 1 sigma |
| cfg_addr_i | input | 7 | Channel number of the table entry |
| cfg_data_i | input | 13 | Table entry value |
| ns_i | input | 5 | Samples per channel (1 to 16), held steady during an event |
| factor_i | input | 12 | Cut factor, 8 fractional bits |
| bypass_i | input | 1 | Keep all well-formed channels |
| chip_id_i | input | 4 | Chip number placed in the header |
| in_valid_i | input | 1 | Sample present |
| in_sample_i | input | 13 | Sample value |
| in_eoc_i | input | 1 | Sample is the last one of its channel |
| busy_o | output | 1 | Frame being sent, samples ignored |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 16 | Output word |
| out_first_o | output | 1 | First word of frame |
| out_last_o | output | 1 | Last word of frame |

## Verification
Two pairs of functions share a cycle by design. The end marker of channel 127 is both the last cut decision and the switch to sending the header, so a malformed or overflowing last channel must still show in that header's error byte; the bench provokes it by giving channel 127 an extra sample and by filling the buffer in bypass mode. A table write presented together with the first sample of an event, or in the middle of one, collides with channel processing; the bench then runs an event whose keep decision for one channel depends on whether that write landed and compares the kept set with a model that leaves the table unchanged.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic {ST_COLLECT, ST_SEND} zs_state_e;
  localparam int ERR_MISMATCH = 0;
  localparam int ERR_OVERFLOW = 1;
  localparam int FRAC_W       = 8;
  localparam int WORD_W       = 16;
  localparam int HDR_WORDS    = 4;
endpackage

// File: rtl/zs_tables.sv
module zs_tables #(
  parameter int N_CH  = 128,
  parameter int VAL_W = 13,
  localparam int AW   = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [VAL_W-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [VAL_W-1:0] ped_o,
  output logic [VAL_W-1:0] sigma_o
);
  logic [VAL_W-1:0] ped_q [N_CH];
  logic [VAL_W-1:0] sig_q [N_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CH; i++) begin
        ped_q[i] <= '0;
        sig_q[i] <= '0;
      end
    end else if (we_i) begin
      if (sel_i) sig_q[wr_addr_i] <= wr_data_i;
      else       ped_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign ped_o   = ped_q[rd_addr_i];
  assign sigma_o = sig_q[rd_addr_i];
endmodule

// File: rtl/zs_cut.sv
module zs_cut #(
  parameter int SAMP_W = 13,
  parameter int NS_W   = 5,
  parameter int FAC_W  = 12,
  localparam int SUM_W = SAMP_W + 1 + NS_W,
  localparam int THR_W = NS_W + SAMP_W + FAC_W,
  localparam int CMP_W = THR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_i,
  input  logic              eval_i,
  input  logic [SAMP_W-1:0] sample_i,
  input  logic [SAMP_W-1:0] ped_i,
  input  logic [SAMP_W-1:0] sigma_i,
  input  logic [NS_W-1:0]   ns_i,
  input  logic [FAC_W-1:0]  factor_i,
  input  logic              bypass_i,
  output logic              keep_o
);
  logic signed [SUM_W-1:0] acc_q, diff, total;
  logic        [THR_W-1:0] thr;
  logic signed [CMP_W-1:0] lhs, rhs;

  always_comb begin
    diff  = $signed({{(SUM_W-SAMP_W){1'b0}}, sample_i}) -
            $signed({{(SUM_W-SAMP_W){1'b0}}, ped_i});
    total = acc_q + (add_i ? diff : '0);
    // mean >= sigma*A rewritten as sum*2^FRAC >= ns*sigma*A_fixed
    thr   = THR_W'(ns_i) * THR_W'(sigma_i) * THR_W'(factor_i);
    lhs   = CMP_W'(total) <<< zs_pkg::FRAC_W;
    rhs   = $signed({2'b00, thr});
    keep_o = bypass_i || (lhs >= rhs);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (eval_i) acc_q <= '0;
    else if (add_i)  acc_q <= total;
  end

  AST_ACC_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |=> (acc_q == '0)); // R2
endmodule

// File: rtl/zs_filter.sv
module zs_filter #(
  parameter int N_CH      = 128,
  parameter int SAMP_W    = 13,
  parameter int MAX_NS    = 16,
  parameter int FAC_W     = 12,
  parameter int BUF_DEPTH = 2048,
  localparam int CH_W     = $clog2(N_CH),
  localparam int NS_W     = $clog2(MAX_NS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [CH_W-1:0]   cfg_addr_i,
  input  logic [SAMP_W-1:0] cfg_data_i,
  input  logic [NS_W-1:0]   ns_i,
  input  logic [FAC_W-1:0]  factor_i,
  input  logic              bypass_i,
  input  logic [3:0]        chip_id_i,
  input  logic              in_valid_i,
  input  logic [SAMP_W-1:0] in_sample_i,
  input  logic              in_eoc_i,
  output logic              busy_o,
  output logic              out_valid_o,
  output logic [15:0]       out_data_o,
  output logic              out_first_o,
  output logic              out_last_o
);
  import zs_pkg::*;

  localparam int CNT_W = NS_W + 1;
  localparam int PTR_W = $clog2(BUF_DEPTH + 1);
  localparam int IDX_W = PTR_W + 1;
  localparam int BAW   = $clog2(BUF_DEPTH);
  localparam int NCH_W = $clog2(N_CH + 1);

  zs_state_e         state_q;
  logic [CH_W-1:0]   ch_q;
  logic [CNT_W-1:0]  smp_q;
  logic [PTR_W-1:0]  commit_q;
  logic [NCH_W-1:0]  nch_q;
  logic [1:0]        err_q;
  logic [IDX_W-1:0]  snd_q;
  logic [WORD_W-1:0] mem_q [BUF_DEPTH];

  logic              accept, in_rng, eoc, last_ch, mism, fits, cut_keep, keep_ch, ovf_ch;
  logic              idle, tbl_we, smp_wr, snd_last;
  logic [IDX_W-1:0]  smp_addr, rd_off;
  logic [SAMP_W-1:0] ped, sigma;
  logic [WORD_W-1:0] snd_word;

  assign accept   = (state_q == ST_COLLECT) && in_valid_i;
  assign in_rng   = smp_q < CNT_W'(ns_i);
  assign eoc      = accept && in_eoc_i;
  assign last_ch  = ch_q == CH_W'(N_CH - 1);
  assign mism     = smp_q != CNT_W'(ns_i) - CNT_W'(1);
  assign fits     = IDX_W'(commit_q) + IDX_W'(ns_i) + IDX_W'(1) <= IDX_W'(BUF_DEPTH);
  assign keep_ch  = eoc && cut_keep && !mism && fits;
  assign ovf_ch   = eoc && cut_keep && !mism && !fits;
  assign smp_addr = IDX_W'(commit_q) + IDX_W'(smp_q) + IDX_W'(1);
  assign smp_wr   = accept && in_rng && (smp_addr < IDX_W'(BUF_DEPTH));
  assign idle     = (state_q == ST_COLLECT) && (ch_q == '0) && (smp_q == '0);
  assign tbl_we   = cfg_we_i && idle && !in_valid_i;
  assign busy_o   = (state_q == ST_SEND);

  zs_tables #(.N_CH(N_CH), .VAL_W(SAMP_W)) u_tables (
    .clk_i, .rst_ni,
    .we_i(tbl_we), .sel_i(cfg_sel_i), .wr_addr_i(cfg_addr_i), .wr_data_i(cfg_data_i),
    .rd_addr_i(ch_q), .ped_o(ped), .sigma_o(sigma)
  );

  zs_cut #(.SAMP_W(SAMP_W), .NS_W(NS_W), .FAC_W(FAC_W)) u_cut (
    .clk_i, .rst_ni,
    .add_i(accept && in_rng), .eval_i(eoc), .sample_i(in_sample_i),
    .ped_i(ped), .sigma_i(sigma), .ns_i, .factor_i, .bypass_i, .keep_o(cut_keep)
  );

  always_ff @(posedge clk_i) begin
    if (smp_wr)  mem_q[smp_addr[BAW-1:0]] <= WORD_W'(in_sample_i);
    if (keep_ch) mem_q[commit_q[BAW-1:0]] <= WORD_W'(ch_q);
  end

  assign rd_off   = snd_q - IDX_W'(HDR_WORDS);
  assign snd_last = snd_q == IDX_W'(commit_q) + IDX_W'(HDR_WORDS - 1);

  always_comb begin
    case (snd_q)
      IDX_W'(0): snd_word = {4'h0, chip_id_i, 8'(nch_q)};
      IDX_W'(1): snd_word = {8'(ns_i), 6'b0, err_q};
      IDX_W'(2), IDX_W'(3): snd_word = '0;
      default:   snd_word = mem_q[rd_off[BAW-1:0]];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_COLLECT;
      ch_q        <= '0;
      smp_q       <= '0;
      commit_q    <= '0;
      nch_q       <= '0;
      err_q       <= '0;
      snd_q       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_first_o <= 1'b0;
      out_last_o  <= 1'b0;
    end else if (state_q == ST_COLLECT) begin
      out_valid_o <= 1'b0;
      out_first_o <= 1'b0;
      out_last_o  <= 1'b0;
      if (eoc) begin
        smp_q <= '0;
        ch_q  <= last_ch ? '0 : ch_q + CH_W'(1);
        if (keep_ch) begin
          commit_q <= commit_q + PTR_W'(ns_i) + PTR_W'(1);
          nch_q    <= nch_q + NCH_W'(1);
        end
        if (mism)   err_q[ERR_MISMATCH] <= 1'b1;
        if (ovf_ch) err_q[ERR_OVERFLOW] <= 1'b1;
        if (last_ch) begin
          state_q <= ST_SEND;
          snd_q   <= '0;
        end
      end else if (accept && smp_q != '1) begin
        smp_q <= smp_q + CNT_W'(1);
      end
    end else begin
      out_valid_o <= 1'b1;
      out_data_o  <= snd_word;
      out_first_o <= (snd_q == '0);
      out_last_o  <= snd_last;
      snd_q       <= snd_q + IDX_W'(1);
      if (snd_last) begin
        state_q  <= ST_COLLECT;
        commit_q <= '0;
        nch_q    <= '0;
        err_q    <= '0;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q <= PTR_W'(BUF_DEPTH)); // R9
  AST_NCH_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nch_q <= NCH_W'(N_CH)); // R7
  AST_HDR_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(in_valid_i && in_eoc_i)); // R7
  AST_FIRST_FROM_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_first_o |-> (out_valid_o && $past(busy_o))); // R11
  AST_LAST_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> !busy_o); // R11
  AST_SEND_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !snd_last) |=> $stable(commit_q)); // R10
endmodule

// File: tb/zs_filter_bench.sv
module zs_filter_bench;
  localparam int N_CH = 128, MAX_NS = 16, DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0, cfg_sel = 0;
  logic [6:0]  cfg_addr = '0;
  logic [12:0] cfg_data = '0;
  logic [4:0]  ns = 5'd4;
  logic [11:0] factor = 12'h100;
  logic        bypass = 0;
  logic [3:0]  chip_id = 4'h0;
  logic        in_valid = 0, in_eoc = 0;
  logic [12:0] in_sample = '0;
  logic        busy, out_valid, out_first, out_last;
  logic [15:0] out_data;

  always #2 clk = ~clk;

  zs_filter u_zs_filter (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .ns_i(ns), .factor_i(factor), .bypass_i(bypass), .chip_id_i(chip_id),
    .in_valid_i(in_valid), .in_sample_i(in_sample), .in_eoc_i(in_eoc),
    .busy_o(busy), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_first_o(out_first), .out_last_o(out_last)
  );

  int n_tests = 0, n_fail = 0;
  int ped_m [N_CH];
  int sig_m [N_CH];
  logic [15:0] exp_q[$], got_q[$];
  int cyc = 0, first_cyc = -1, eoc_cyc = 0, flag_err = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid) begin
      got_q.push_back(out_data);
      if (out_first) first_cyc = cyc;
      if (out_first != (got_q.size() == 1)) flag_err++;
      if (out_last != (got_q.size() == exp_q.size())) flag_err++;
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(bit sel, int addr, int val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_addr = 7'(addr); cfg_data = 13'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // mode: 0 random charge, 1 directed threshold edge, 2 channel 3 fixed at 220
  task automatic run_event(int ens, int fac, bit byp, int mode, int short_ch, int long_ch,
                           int blk_ch, bit noise, string req);
    int smp [N_CH][MAX_NS+1];
    int cnt [N_CH];
    int used = 0, nch = 0, err = 0;
    logic [15:0] recs[$];
    for (int c = 0; c < N_CH; c++) begin
      longint sum = 0, thr;
      bit keep;
      cnt[c] = ens;
      if (c == short_ch) cnt[c] = ens - 1;
      if (c == long_ch)  cnt[c] = ens + 1;
      for (int k = 0; k < cnt[c]; k++) begin
        int off = int'($urandom_range(0, 40)) - 10;
        if (mode == 1) off = (c == 0) ? 8 : (c == 1) ? ((k == 3) ? 7 : 8) : 0;
        smp[c][k] = ped_m[c] + off;
        if (mode == 2 && c == 3) smp[c][k] = 220;
        if (k < ens) sum += smp[c][k] - ped_m[c];
      end
      thr  = longint'(ens) * sig_m[c] * fac;
      keep = byp || (sum * 256 >= thr);
      if (cnt[c] != ens) err |= 1;
      else if (keep) begin
        if (used + ens + 1 <= DEPTH) begin
          recs.push_back(16'(c));
          for (int k = 0; k < ens; k++) recs.push_back(16'(smp[c][k]));
          used += ens + 1;
          nch++;
        end else err |= 2;
      end
    end
    exp_q.delete();
    exp_q.push_back({4'h0, chip_id, 8'(nch)});
    exp_q.push_back({8'(ens), 8'(err)});
    exp_q.push_back(16'h0);
    exp_q.push_back(16'h0);
    foreach (recs[i]) exp_q.push_back(recs[i]);

    got_q.delete();
    flag_err = 0;
    first_cyc = -1;
    ns = 5'(ens); factor = 12'(fac); bypass = byp;
    for (int c = 0; c < N_CH; c++) begin
      for (int k = 0; k < cnt[c]; k++) begin
        @(negedge clk);
        in_valid = 1; in_sample = 13'(smp[c][k]); in_eoc = (k == cnt[c] - 1);
        if (c == blk_ch && k == 0) begin
          cfg_we = 1; cfg_sel = 0; cfg_addr = 7'd3; cfg_data = 13'd1000;
        end else cfg_we = 0;
        if (c == N_CH - 1 && in_eoc) eoc_cyc = cyc;
      end
    end
    @(negedge clk);
    cfg_we = 0;
    while (busy) begin
      in_valid  = noise ? 1'($urandom_range(0, 1)) : 1'b0;
      in_eoc    = 1'($urandom_range(0, 1));
      in_sample = 13'($urandom_range(0, 8191));
      @(negedge clk);
    end
    in_valid = 0; in_eoc = 0;
    @(negedge clk);

    check(got_q.size() == exp_q.size(), {req, " R7 frame length"}, got_q.size(), exp_q.size());
    check(first_cyc == eoc_cyc + 2, "R7 header timing", first_cyc - eoc_cyc, 2);
    check(flag_err == 0, "R11 first/last marks", flag_err, 0);
    if (got_q.size() >= 2) begin
      check(got_q[0] == exp_q[0], "R5 header word0", got_q[0], exp_q[0]);
      check(got_q[1] == exp_q[1], "R8 R9 header ns/err", got_q[1], exp_q[1]);
    end
    if (got_q.size() == exp_q.size()) begin
      int bad = 0, at = 0;
      for (int i = 2; i < exp_q.size(); i++)
        if (got_q[i] !== exp_q[i]) begin
          if (bad == 0) at = i;
          bad++;
        end
      check(bad == 0, {req, " R6 records"}, got_q[at], exp_q[at]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R7 watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c1a));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!out_valid && !out_first && !out_last, "R1 outputs idle", out_valid, 0);
    check(!busy, "R1 busy low", busy, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3: sigma 8, factor 1.0, ns 4 -> sum 32 kept exactly at threshold, 31 dropped
    chip_id = 4'h5;
    for (int c = 0; c < N_CH; c++) begin
      ped_m[c] = 100; sig_m[c] = 8;
      cfg_write(0, c, 100);
      cfg_write(1, c, 8);
    end
    run_event(4, 12'h100, 0, 1, -1, -1, -1, 0, "R2 R3 threshold edge");

    // random tables, factor 0.8 (R3)
    for (int c = 0; c < N_CH; c++) begin
      ped_m[c] = int'($urandom_range(50, 600));
      sig_m[c] = int'($urandom_range(0, 12));
      cfg_write(0, c, ped_m[c]);
      cfg_write(1, c, sig_m[c]);
    end
    chip_id = 4'hA;
    run_event(8, 12'h0CC, 0, 0, -1, -1, -1, 1, "R2 R3 R10 random 0.8");
    run_event(3, 12'h180, 0, 0, -1, -1, -1, 0, "R2 random 1.5");
    // R4 bypass keeps all 128
    run_event(3, 12'hFFF, 1, 0, -1, -1, -1, 0, "R4 bypass");
    // R8 short channel 5, long last channel 127 (same cycle as header switch)
    chip_id = 4'hF;
    run_event(6, 12'h0CC, 0, 0, 5, 127, -1, 0, "R8 mismatch");
    // R9 overflow: 16 samples in bypass, 120 records fit
    run_event(16, 12'h100, 1, 0, -1, -1, -1, 0, "R9 overflow");

    // R10: writes mid-event and alongside first sample are ignored
    ped_m[3] = 200; sig_m[3] = 8;
    cfg_write(0, 3, 200);
    cfg_write(1, 3, 8);
    run_event(4, 12'h100, 0, 2, -1, -1, 10, 0, "R10 write mid-event");
    run_event(4, 12'h100, 0, 2, -1, -1, 0, 0, "R10 write with first sample");
    // idle write lands: channel 3 now below pedestal and dropped
    ped_m[3] = 1000;
    cfg_write(0, 3, 1000);
    run_event(4, 12'h100, 0, 2, -1, -1, -1, 0, "R10 idle write");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule